// File: doc/BRIEF.md
# Accumulator Binary/Decimal Adder Unit

This block is the arithmetic core of a small, non-pipelined accumulator CPU. Each operation adds a chosen second operand to the accumulator. The second operand is the external data byte, its bitwise inverse, the constant +1, the constant -1, or zero. The operation is one of four: add, add with carry, subtract, or subtract with borrow. Each operation runs either in plain binary or in packed decimal (two BCD digits per byte).

All four operations share one adder. Subtraction inverts the second operand in front of that adder and feeds the carry input, so carry means "not borrow" for subtraction. The adder is two bits wider than the word. Its top bit gives the carry and its sign-extension bit gives signed overflow. The carry into each 4-bit digit is recovered from the same sum, so no second adder is needed. A per-digit correction stage sits after the adder for decimal mode.

On a write strobe, the result is stored in the accumulator register. The carry, digit carry, negative, zero and overflow flags are stored in the flag register at the same time. The stored carry is the carry input for the with-carry operations. The accumulator is loaded by arithmetic: subtract its own value, then add the new byte.

Top module: `acc_bcd_alu`

## Requirements
- R1: While `rst_n` is low, the accumulator and all five flags read 0.
- R2: With `wr_en` low, a clock edge leaves the accumulator and all flags unchanged, whatever the other inputs are.
- R3: Binary `op`=0 (add) writes acc+src. Binary `op`=1 (add with carry) writes acc+src+C. C becomes the carry out of bit 7.
- R4: Binary `op`=2 (subtract) writes acc-src. Binary `op`=3 (subtract with borrow) writes acc-src-(1-C). C becomes 1 when no borrow occurred. Subtract always uses a carry input of 1.
- R5: `src_sel` encodings: 0 = operand, 1 = inverted operand, 2 = 0x01, 3 = 0xFF, 4 to 7 = zero.
- R6: In binary mode, V is set when the two's-complement result of the operation does not fit in 8 bits.
- R7: N equals bit 7 of the written result. Z is 1 exactly when the written result is 0x00. Both hold in both modes.
- R8: H is the carry out of the low 4-bit digit, with the carry input included. For subtraction it is the low-digit not-borrow. It is computed this way in both modes.
- R9: In decimal mode with valid BCD inputs, add and add-with-carry write the decimal sum modulo 100. C is set when the decimal sum exceeds 99.
- R10: In decimal mode with valid BCD inputs, subtract and subtract-with-borrow write the decimal difference modulo 100. C is 1 when no borrow occurred.
- R11: A decimal-mode write leaves V unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the accumulator and flags |
| src_sel | input | 3 | Second-operand select (R5) |
| op | input | 2 | Operation: 0 add, 1 add+carry, 2 sub, 3 sub+borrow |
| dec_mode | input | 1 | 1 = packed decimal mode |
| opnd | input | DATA_W | External operand byte |
| acc_q | output | DATA_W | Accumulator register |
| c_q | output | 1 | Carry / not-borrow flag |
| h_q | output | 1 | Low-digit carry flag |
| n_q | output | 1 | Negative flag |
| z_q | output | 1 | Zero flag |
| v_q | output | 1 | Overflow flag |

## Verification
The bench builds the block with its defaults: DATA_W = 8 and the decimal stage enabled. With these values, both digit boundaries and both decimal-correction paths appear on every operation. The 8-bit operand space is also small enough that a few hundred pseudo-random steps reach the 0x7F/0x80 overflow edges, the 99-to-00 decimal wrap and the 00-minus-1 decimal borrow. Those edges are also driven by directed steps.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_ADC = 2'd1,
      OP_SUB = 2'd2,
      OP_SBB = 2'd3
   } alu_op_e;

   typedef enum logic [2:0] {
      SRC_OPND  = 3'd0,
      SRC_NOPND = 3'd1,
      SRC_INC   = 3'd2,
      SRC_DEC   = 3'd3,
      SRC_ZERO  = 3'd4
   } src_sel_e;

   localparam int unsigned DIGIT_W = 4;

endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel
   import acc_alu_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] opnd,
   input  logic [2:0]   src_sel,
   input  logic [1:0]   op,
   input  logic         carry_flag,
   output logic [W-1:0] b_eff,
   output logic         cin,
   output logic         is_sub
);
   logic [W-1:0] src;

   always_comb begin
      case (src_sel)
         SRC_OPND:  src = opnd;
         SRC_NOPND: src = ~opnd;
         SRC_INC:   src = {{(W-1){1'b0}}, 1'b1};
         SRC_DEC:   src = {W{1'b1}};
         default:   src = '0;
      endcase
   end

   always_comb begin
      case (alu_op_e'(op))
         OP_ADD:  begin is_sub = 1'b0; cin = 1'b0;       end
         OP_ADC:  begin is_sub = 1'b0; cin = carry_flag; end
         OP_SUB:  begin is_sub = 1'b1; cin = 1'b1;       end
         default: begin is_sub = 1'b1; cin = carry_flag; end
      endcase
   end

   // complement sits in front of the shared adder
   assign b_eff = is_sub ? ~src : src;

endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int unsigned W   = 8,
   parameter int unsigned DIG = 4
) (
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic             cin,
   output logic [W-1:0]     sum,
   output logic             c_out,
   output logic             v_out,
   output logic [W/DIG-1:0] dig_c
);
   localparam int unsigned EXT  = W + 2;
   localparam int unsigned NDIG = W / DIG;

   logic [EXT-1:0] a_x, b_x, s_x, cin_vec;

   assign a_x = {1'b0, a[W-1], a};
   assign b_x = {1'b0, b[W-1], b};
   // one widened adder: sign-extension bit for overflow, top bit for carry
   assign s_x = a_x + b_x + {{(EXT-1){1'b0}}, cin};
   // carry arriving at each bit position, recovered from the same sum
   assign cin_vec = s_x ^ a_x ^ b_x;

   assign sum   = s_x[W-1:0];
   assign c_out = s_x[W+1];
   assign v_out = s_x[W] ^ s_x[W-1];

   for (genvar g = 0; g < NDIG; g++) begin : g_dig
      assign dig_c[g] = cin_vec[(g+1)*DIG];
   end

endmodule

// File: rtl/acc_alu_decfix.sv
module acc_alu_decfix #(
   parameter int unsigned W   = 8,
   parameter int unsigned DIG = 4
) (
   input  logic [W-1:0]     raw,
   input  logic [W/DIG-1:0] dig_c,
   input  logic             is_sub,
   output logic [W-1:0]     fixed,
   output logic             dec_c
);
   localparam int unsigned NDIG = W / DIG;

   logic [NDIG:0]   kc;
   logic [NDIG-1:0] need_add;

   assign kc[0] = 1'b0;

   for (genvar g = 0; g < NDIG; g++) begin : g_dig
      logic [DIG-1:0] nib;
      logic [DIG:0]   t_w;
      logic [DIG:0]   a_w;
      logic [DIG-1:0] s_w;

      assign nib         = raw[g*DIG +: DIG];
      // correction carry from the digit below joins this digit
      assign t_w         = {1'b0, nib} + {{DIG{1'b0}}, kc[g]};
      assign need_add[g] = dig_c[g] | (t_w > 5'd9);
      assign a_w         = need_add[g] ? (t_w + 5'd6) : t_w;
      assign kc[g+1]     = a_w[DIG];
      // subtract: a digit that borrowed loses six
      assign s_w         = dig_c[g] ? nib : (nib - 4'd6);
      assign fixed[g*DIG +: DIG] = is_sub ? s_w : a_w[DIG-1:0];
   end

   assign dec_c = is_sub ? dig_c[NDIG-1] : need_add[NDIG-1];

endmodule

// File: rtl/acc_bcd_alu.sv
module acc_bcd_alu
   import acc_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit          DEC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        src_sel,
   input  logic [1:0]        op,
   input  logic              dec_mode,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] acc_q,
   output logic              c_q,
   output logic              h_q,
   output logic              n_q,
   output logic              z_q,
   output logic              v_q
);
   localparam int unsigned NDIG = DATA_W / DIGIT_W;

   if ((DATA_W % DIGIT_W) != 0 || DATA_W < 2*DIGIT_W) begin : g_bad_width
      $error("acc_bcd_alu: DATA_W must be a multiple of the digit width and hold two digits");
   end

   logic [DATA_W-1:0] b_eff, raw_sum, fixed, res;
   logic              cin, is_sub, bin_c, bin_v, dec_c, dec_act;
   logic [NDIG-1:0]   dig_c;

   acc_alu_opsel #(.W(DATA_W)) u_opsel (
      .opnd(opnd), .src_sel(src_sel), .op(op), .carry_flag(c_q),
      .b_eff(b_eff), .cin(cin), .is_sub(is_sub)
   );

   acc_alu_adder #(.W(DATA_W), .DIG(DIGIT_W)) u_adder (
      .a(acc_q), .b(b_eff), .cin(cin),
      .sum(raw_sum), .c_out(bin_c), .v_out(bin_v), .dig_c(dig_c)
   );

   if (DEC_EN) begin : g_dec
      acc_alu_decfix #(.W(DATA_W), .DIG(DIGIT_W)) u_fix (
         .raw(raw_sum), .dig_c(dig_c), .is_sub(is_sub),
         .fixed(fixed), .dec_c(dec_c)
      );
      assign dec_act = dec_mode;
   end else begin : g_bin
      assign fixed   = raw_sum;
      assign dec_c   = bin_c;
      assign dec_act = 1'b0;
   end

   assign res = dec_act ? fixed : raw_sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         c_q   <= 1'b0;
         h_q   <= 1'b0;
         n_q   <= 1'b0;
         z_q   <= 1'b0;
         v_q   <= 1'b0;
      end else if (wr_en) begin
         acc_q <= res;
         c_q   <= dec_act ? dec_c : bin_c;
         h_q   <= dig_c[0];
         n_q   <= res[DATA_W-1];
         z_q   <= (res == '0);
         v_q   <= dec_act ? v_q : bin_v;
      end
   end

   function automatic logic bcd_ok(input logic [DATA_W-1:0] x);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < NDIG; i++) begin
         if (x[i*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
      end
      return ok;
   endfunction

   // R2: no strobe, no change
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(acc_q) && $stable({c_q, h_q, n_q, z_q, v_q})));

   // R7: zero and negative agree with the stored accumulator
   p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (z_q == (acc_q == '0)));
   p_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (n_q == acc_q[DATA_W-1]));

   // R11: decimal writes keep overflow
   p_vkeep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dec_mode && DEC_EN) |=> $stable(v_q));

   // R3: adding zero keeps the accumulator and clears carry
   p_addzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !dec_mode && op == OP_ADD && src_sel == SRC_ZERO)
      |=> (acc_q == $past(acc_q) && !c_q));

   // R4: subtracting zero never borrows
   p_subzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !dec_mode && op == OP_SUB && src_sel == SRC_ZERO)
      |=> (acc_q == $past(acc_q) && c_q));

   // R9: decimal add of valid digits gives valid digits
   p_bcd_digits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dec_mode && DEC_EN && !op[1] && src_sel == SRC_OPND
       && bcd_ok(acc_q) && bcd_ok(opnd)) |=> bcd_ok(acc_q));

endmodule

// File: tb/acc_bcd_alu_tb_top.sv
`timescale 1ns/1ps
module acc_bcd_alu_tb_top;
   localparam real CLK_P = 4.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] src_sel = '0;
   logic [1:0] op = '0;
   logic       dec_mode = 1'b0;
   logic [7:0] opnd = '0;
   logic [7:0] acc_q;
   logic       c_q, h_q, n_q, z_q, v_q;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   int m_acc = 0, m_c = 0, m_h = 0, m_n = 0, m_z = 0, m_v = 0;
   int unsigned seed = 32'h1234_5678;

   always #(CLK_P/2) clk = ~clk;

   acc_bcd_alu dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .src_sel(src_sel), .op(op),
      .dec_mode(dec_mode), .opnd(opnd), .acc_q(acc_q), .c_q(c_q), .h_q(h_q),
      .n_q(n_q), .z_q(z_q), .v_q(v_q)
   );

   function automatic int unsigned rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   function automatic int to_bcd(input int d);
      return ((d / 10) % 10) * 16 + (d % 10);
   endfunction

   function automatic int from_bcd(input int x);
      return (x / 16) * 10 + (x % 16);
   endfunction

   task automatic chk(input string tag, input string nm, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
      end
   endtask

   task automatic cmp_all(input string tag);
      chk(tag, "acc", int'(acc_q), m_acc);
      chk(tag, "C", int'(c_q), m_c);
      chk(tag, "H", int'(h_q), m_h);
      chk(tag, "N", int'(n_q), m_n);
      chk(tag, "Z", int'(z_q), m_z);
      chk(tag, "V", int'(v_q), m_v);
   endtask

   // reference model: decimal/integer arithmetic, one step per clock
   task automatic step(input int s, input int o, input int d, input int x,
                       input int w, input string tag);
      int sv, cin, sub, r, bb, sa, sb, ss, e_acc, e_c, e_h, e_v;
      @(negedge clk);
      src_sel = 3'(s); op = 2'(o); dec_mode = d[0]; opnd = 8'(x); wr_en = w[0];
      case (s)
         0: sv = x;
         1: sv = 255 - x;
         2: sv = 1;
         3: sv = 255;
         default: sv = 0;
      endcase
      sub = (o >= 2);
      cin = (o == 0) ? 0 : (o == 2) ? 1 : m_c;
      bb  = sub ? (255 - sv) : sv;
      e_h = (((m_acc % 16) + (bb % 16) + cin) >= 16);
      e_v = m_v;
      if (d != 0) begin
         if (!sub) begin
            r = from_bcd(m_acc) + from_bcd(sv) + cin;
            e_c = (r > 99);
            e_acc = to_bcd(r % 100);
         end else begin
            r = from_bcd(m_acc) - from_bcd(sv) - (1 - cin);
            e_c = (r >= 0);
            e_acc = to_bcd((r + 100) % 100);
         end
      end else begin
         sa = (m_acc >= 128) ? m_acc - 256 : m_acc;
         sb = (sv >= 128) ? sv - 256 : sv;
         if (!sub) begin
            r = m_acc + sv + cin;
            e_c = (r > 255);
            ss = sa + sb + cin;
         end else begin
            r = m_acc - sv - (1 - cin);
            e_c = (r >= 0);
            ss = sa - sb - (1 - cin);
         end
         e_acc = (r + 512) % 256;
         e_v = (ss > 127 || ss < -128);
      end
      @(posedge clk);
      #1;
      if (w != 0) begin
         m_acc = e_acc; m_c = e_c; m_h = e_h; m_v = e_v;
         m_n = (e_acc >= 128); m_z = (e_acc == 0);
      end
      cmp_all(tag);
   endtask

   task automatic load(input int x);
      step(0, 2, 0, m_acc, 1, "R4 load-clear");
      step(0, 0, 0, x, 1, "R3 load-set");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      cmp_all("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // binary directed
      step(0, 0, 0, 8'h7F, 1, "R3 add");
      step(2, 0, 0, 0, 1, "R6 7F+1 overflow");
      step(3, 0, 0, 0, 1, "R6 80-1 via add FF");
      step(0, 2, 0, 8'h01, 1, "R4 sub no borrow");
      step(0, 2, 0, 8'h80, 1, "R4 sub borrow");
      step(0, 1, 0, 8'h10, 1, "R3 adc");
      step(1, 0, 0, 8'h0F, 1, "R5 inverted operand");
      step(6, 0, 0, 8'h55, 1, "R5 code 6 zero");
      step(4, 3, 0, 0, 1, "R4 sbb");
      step(0, 0, 0, 8'h08, 1, "R8 digit carry");
      step(0, 2, 0, 8'h09, 1, "R8 digit borrow");
      load(0);
      step(0, 0, 0, 0, 1, "R7 zero");
      step(3, 0, 7, 8'hAA, 0, "R2 hold");
      step(0, 3, 1, 8'h33, 0, "R2 hold dec");

      // decimal directed
      load(8'h99);
      step(2, 0, 1, 0, 1, "R9 99+1 wrap");
      step(2, 2, 1, 0, 1, "R10 00-1 borrow");
      step(0, 3, 1, 8'h50, 1, "R10 sbb");
      step(0, 1, 1, 8'h99, 1, "R9 adc");
      load(8'h7F);
      step(2, 0, 0, 0, 1, "R6 set V");
      load(8'h45);
      step(0, 0, 1, 8'h55, 1, "R11 V kept");

      // pseudo-random binary
      for (int i = 0; i < 300; i++) begin
         int s, o, x, w;
         s = int'(rnd() % 8); o = int'(rnd() % 4);
         x = int'(rnd() % 256); w = (rnd() % 8) != 0;
         step(s, o, 0, x, w, (o >= 2) ? "R4 rnd" : "R3 rnd");
      end

      // pseudo-random decimal
      load(to_bcd(int'(rnd() % 100)));
      for (int i = 0; i < 300; i++) begin
         int k, s, o, x;
         k = int'(rnd() % 4);
         s = (k == 0) ? 2 : (k == 1) ? 4 : 0;
         o = int'(rnd() % 4);
         x = to_bcd(int'(rnd() % 100));
         step(s, o, 1, x, 1, (o >= 2) ? "R10 rnd" : "R9 rnd");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule